// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block performs the state change a processor core makes when it takes an exception. Each cycle it looks at a bit vector of pending exception requests, together with the current program counter, the current status word, the condition flags and three control bits. When at least one request is pending, it picks the most urgent one. On the next clock edge it presents everything the core needs to enter the handler: the new status word, the return address for the link register, a write into the saved-status register banked for the handler's mode, and the new fetch address with its sequential successor.

Each exception class carries its own vector slot, handler mode, link adjustment and mask policy. The link adjustment takes separate values for 32-bit and 16-bit instruction state. All outputs are registered and change together on the clock edge that raises the one-cycle entry strobe. The core applies them as one atomic update.

Status word layout used on every status port: mode field bits [4:0], instruction-set state bit 5 (1 = 16-bit), fast-interrupt mask bit 6, interrupt mask bit 7, asynchronous-abort mask bit 8, if-then state bits [15:10] and [26:25], J bit 24, condition flags [31:28]. All other bits are carried through unchanged.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request bits are 0 reset, 1 undefined instruction, 2 supervisor call, 3 prefetch abort, 4 data abort, 5 IRQ, 6 FIQ. One clock after a cycle with any request bit set, `entry_valid_o` is high for that cycle and `entry_cause_o` holds the index of the winner. The order from most to least urgent is reset, data abort, FIQ, IRQ, prefetch abort, undefined, supervisor call. One clock after a cycle with no request, `entry_valid_o` is low.
- R2: `new_pc_o` is the vector offset of the winner: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, IRQ 0x18, FIQ 0x1C. When `ctl_hivec_i` is 1, 0xFFFF0000 is added. Offset 0x14 is never produced.
- R3: The mode field of `new_status_o` is 0x13 for reset and supervisor call, 0x1B for undefined, 0x17 for both aborts, 0x12 for IRQ and 0x11 for FIQ.
- R4: With status bit 5 of `status_i` clear, `link_o` equals `pc_i` plus 0 for reset, plus 8 for data abort, and plus 4 for every other class, all modulo 2^32.
- R5: With status bit 5 of `status_i` set, `link_o` equals `pc_i` plus 0 for reset, plus 2 for undefined and supervisor call, plus 4 for prefetch abort, IRQ and FIQ, and plus 8 for data abort.
- R6: In `new_status_o`, bit 7 is always 1. Bit 8 is forced to 1 for reset, both aborts, IRQ and FIQ, and otherwise keeps its value from `status_i`. Bit 6 is forced to 1 only for reset and FIQ, and otherwise keeps its value.
- R7: In `new_status_o`, if-then bits and the J bit are 0 and bit 5 equals `ctl_te_i`. Every bit not named in R3, R6 or R7 equals the same bit of `status_i`.
- R8: On every entry, `saved_we_o` is 1 and `mode_err_o` is 0. `saved_o` equals `status_i` with `flags_i` ORed into bits [31:28]. `saved_bank_o` selects the bank: 0 FIQ, 1 IRQ, 2 supervisor, 3 undefined, 4 abort. A handler mode with no bank would give `mode_err_o` high and no write.
- R9: `next_pc_o` equals `new_pc_o` plus 2 when `ctl_te_i` is 1, and plus 4 otherwise.
- R10: When `ctl_vecirq_i` is 1 during a request, `vec_err_o` is high with the entry strobe. The entry is still carried out unchanged.
- R11: A synchronous active-high reset clears every output to 0. Outputs other than the strobes hold their values between entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 7 | Pending exception requests, one bit per class |
| pc_i | input | 32 | PC of the interrupted instruction stream |
| status_i | input | 32 | Current status word |
| flags_i | input | 4 | Current condition flags |
| ctl_te_i | input | 1 | Handlers run in 16-bit instruction state |
| ctl_hivec_i | input | 1 | Use high vector base |
| ctl_vecirq_i | input | 1 | Vectored interrupts requested (unsupported) |
| entry_valid_o | output | 1 | One-cycle entry strobe |
| entry_cause_o | output | 3 | Index of the exception taken |
| new_status_o | output | 32 | Status word for the handler |
| link_o | output | 32 | Value for the link register |
| saved_we_o | output | 1 | Saved-status write enable |
| saved_bank_o | output | 3 | Saved-status bank select |
| saved_o | output | 32 | Saved-status write data |
| new_pc_o | output | 32 | Handler fetch address |
| next_pc_o | output | 32 | Sequential address after the first handler fetch |
| vec_err_o | output | 1 | Vectored-interrupt request flagged as unsupported |
| mode_err_o | output | 1 | Handler mode has no saved-status bank |

## Verification
Arbitration and per-class attribute selection meet in the same cycle whenever several request bits are set. The handler mode, masks, link offset and vector must then all belong to the winner and not to a loser. The bench provokes this by sweeping all 127 non-empty request masks. Each mask is crossed with both instruction states, both handler states, both vector bases and the vectored-interrupt bit. For each combination the bench recomputes the winner and every output field arithmetically and compares the whole entry record. A stray loser attribute shows up as a field mismatch.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int NUM_EXC = 7;
  localparam int CAUSE_W = 3;
  localparam int SR_W    = 32;
  localparam int MODE_W  = 5;
  localparam int BANK_W  = 3;

  // status word field positions
  localparam int SB_T      = 5;
  localparam int SB_F      = 6;
  localparam int SB_I      = 7;
  localparam int SB_A      = 8;
  localparam int SB_J      = 24;
  localparam int SB_FLAG_L = 28;
  localparam logic [SR_W-1:0] SR_ITJ_MASK = 32'h0700_FC00;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_RESET = 3'd0,
    EXC_UNDEF = 3'd1,
    EXC_SVC   = 3'd2,
    EXC_PABT  = 3'd3,
    EXC_DABT  = 3'd4,
    EXC_IRQ   = 3'd5,
    EXC_FIQ   = 3'd6
  } exc_id_t;

  localparam logic [MODE_W-1:0] MD_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MD_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MD_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MD_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MD_UND = 5'h1B;

  typedef enum logic [BANK_W-1:0] {
    BK_FIQ = 3'd0,
    BK_IRQ = 3'd1,
    BK_SVC = 3'd2,
    BK_UND = 3'd3,
    BK_ABT = 3'd4
  } bank_t;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [4:0]        vec_off;
    logic [3:0]        lr_wide;
    logic [3:0]        lr_narrow;
    logic              set_a;
    logic              set_f;
  } exc_attr_t;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic [NUM_EXC-1:0] req_i,
  output logic               any_o,
  output exc_id_t            win_o
);
  // most urgent first
  localparam exc_id_t ORDER [NUM_EXC] = '{EXC_RESET, EXC_DABT, EXC_FIQ,
                                          EXC_IRQ, EXC_PABT, EXC_UNDEF, EXC_SVC};

  logic [NUM_EXC:0] claimed;
  logic [NUM_EXC-1:0] grant;

  assign claimed[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < NUM_EXC; g++) begin : g_rank
      assign grant[g]     = req_i[ORDER[g]] & ~claimed[g];
      assign claimed[g+1] = claimed[g] | req_i[ORDER[g]];
    end
  endgenerate

  always_comb begin
    win_o = EXC_RESET;
    for (int i = 0; i < NUM_EXC; i++)
      if (grant[i]) win_o = ORDER[i];
  end

  assign any_o = claimed[NUM_EXC];
endmodule

// File: rtl/exc_class_table.sv
module exc_class_table
  import exc_entry_pkg::*;
(
  input  exc_id_t   id_i,
  output exc_attr_t attr_o
);
  always_comb begin
    unique case (id_i)
      EXC_RESET: attr_o = '{mode: MD_SVC, vec_off: 5'h00, lr_wide: 4'd0, lr_narrow: 4'd0, set_a: 1'b1, set_f: 1'b1};
      EXC_UNDEF: attr_o = '{mode: MD_UND, vec_off: 5'h04, lr_wide: 4'd4, lr_narrow: 4'd2, set_a: 1'b0, set_f: 1'b0};
      EXC_SVC:   attr_o = '{mode: MD_SVC, vec_off: 5'h08, lr_wide: 4'd4, lr_narrow: 4'd2, set_a: 1'b0, set_f: 1'b0};
      EXC_PABT:  attr_o = '{mode: MD_ABT, vec_off: 5'h0C, lr_wide: 4'd4, lr_narrow: 4'd4, set_a: 1'b1, set_f: 1'b0};
      EXC_DABT:  attr_o = '{mode: MD_ABT, vec_off: 5'h10, lr_wide: 4'd8, lr_narrow: 4'd8, set_a: 1'b1, set_f: 1'b0};
      EXC_IRQ:   attr_o = '{mode: MD_IRQ, vec_off: 5'h18, lr_wide: 4'd4, lr_narrow: 4'd4, set_a: 1'b1, set_f: 1'b0};
      EXC_FIQ:   attr_o = '{mode: MD_FIQ, vec_off: 5'h1C, lr_wide: 4'd4, lr_narrow: 4'd4, set_a: 1'b1, set_f: 1'b1};
      default:   attr_o = '{mode: MD_SVC, vec_off: 5'h00, lr_wide: 4'd0, lr_narrow: 4'd0, set_a: 1'b1, set_f: 1'b1};
    endcase
  end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
)(
  input  exc_attr_t         attr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [SR_W-1:0]   status_i,
  input  logic [3:0]        flags_i,
  input  logic              ctl_te_i,
  input  logic              ctl_hivec_i,
  output logic [SR_W-1:0]   new_status_o,
  output logic [SR_W-1:0]   saved_o,
  output logic [XLEN-1:0]   link_o,
  output logic [XLEN-1:0]   new_pc_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic [BANK_W-1:0] bank_o,
  output logic              bank_ok_o
);
  localparam int VOFF_W = $bits(attr_i.vec_off);

  logic [XLEN-1:0] vec_base;
  logic [3:0]      lr_adj;

  always_comb begin
    new_status_o = status_i & ~SR_ITJ_MASK;
    new_status_o[MODE_W-1:0] = attr_i.mode;
    new_status_o[SB_T] = ctl_te_i;
    new_status_o[SB_A] = status_i[SB_A] | attr_i.set_a;
    new_status_o[SB_F] = status_i[SB_F] | attr_i.set_f;
    new_status_o[SB_I] = 1'b1;
  end

  always_comb begin
    saved_o = status_i;
    saved_o[SB_FLAG_L +: 4] = status_i[SB_FLAG_L +: 4] | flags_i;
  end

  assign lr_adj   = status_i[SB_T] ? attr_i.lr_narrow : attr_i.lr_wide;
  assign link_o   = pc_i + XLEN'(lr_adj);
  assign vec_base = ctl_hivec_i ? HIVEC_BASE : '0;
  assign new_pc_o = vec_base + {{(XLEN-VOFF_W){1'b0}}, attr_i.vec_off};
  assign next_pc_o = new_pc_o + (ctl_te_i ? XLEN'(2) : XLEN'(4));

  always_comb begin
    bank_ok_o = 1'b1;
    unique case (attr_i.mode)
      MD_FIQ:  bank_o = BK_FIQ;
      MD_IRQ:  bank_o = BK_IRQ;
      MD_SVC:  bank_o = BK_SVC;
      MD_UND:  bank_o = BK_UND;
      MD_ABT:  bank_o = BK_ABT;
      default: begin bank_o = BK_FIQ; bank_ok_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HIVEC_BASE = 32'hFFFF_0000
)(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_EXC-1:0]  req_i,
  input  logic [XLEN-1:0]     pc_i,
  input  logic [SR_W-1:0]     status_i,
  input  logic [3:0]          flags_i,
  input  logic                ctl_te_i,
  input  logic                ctl_hivec_i,
  input  logic                ctl_vecirq_i,
  output logic                entry_valid_o,
  output logic [CAUSE_W-1:0]  entry_cause_o,
  output logic [SR_W-1:0]     new_status_o,
  output logic [XLEN-1:0]     link_o,
  output logic                saved_we_o,
  output logic [BANK_W-1:0]   saved_bank_o,
  output logic [SR_W-1:0]     saved_o,
  output logic [XLEN-1:0]     new_pc_o,
  output logic [XLEN-1:0]     next_pc_o,
  output logic                vec_err_o,
  output logic                mode_err_o
);
  logic              take;
  exc_id_t           win;
  exc_attr_t         attr;
  logic [SR_W-1:0]   c_status, c_saved;
  logic [XLEN-1:0]   c_link, c_pc, c_next;
  logic [BANK_W-1:0] c_bank;
  logic              c_bank_ok;

  exc_arbiter u_arb (
    .req_i (req_i),
    .any_o (take),
    .win_o (win)
  );

  exc_class_table u_tab (
    .id_i   (win),
    .attr_o (attr)
  );

  exc_state_calc #(.XLEN(XLEN), .HIVEC_BASE(HIVEC_BASE)) u_calc (
    .attr_i       (attr),
    .pc_i         (pc_i),
    .status_i     (status_i),
    .flags_i      (flags_i),
    .ctl_te_i     (ctl_te_i),
    .ctl_hivec_i  (ctl_hivec_i),
    .new_status_o (c_status),
    .saved_o      (c_saved),
    .link_o       (c_link),
    .new_pc_o     (c_pc),
    .next_pc_o    (c_next),
    .bank_o       (c_bank),
    .bank_ok_o    (c_bank_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_valid_o <= 1'b0;
      entry_cause_o <= '0;
      new_status_o  <= '0;
      link_o        <= '0;
      saved_we_o    <= 1'b0;
      saved_bank_o  <= '0;
      saved_o       <= '0;
      new_pc_o      <= '0;
      next_pc_o     <= '0;
      vec_err_o     <= 1'b0;
      mode_err_o    <= 1'b0;
    end else begin
      entry_valid_o <= take;
      saved_we_o    <= take & c_bank_ok;
      mode_err_o    <= take & ~c_bank_ok;
      vec_err_o     <= take & ctl_vecirq_i;
      if (take) begin
        entry_cause_o <= win;
        new_status_o  <= c_status;
        link_o        <= c_link;
        saved_bank_o  <= c_bank;
        saved_o       <= c_saved;
        new_pc_o      <= c_pc;
        next_pc_o     <= c_next;
      end
    end
  end
endmodule

// File: rtl/exc_entry_ctrl_chk.sv
module exc_entry_ctrl_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
)(
  input logic                clk,
  input logic                rst,
  input logic [NUM_EXC-1:0]  req_i,
  input logic                entry_valid_o,
  input logic [CAUSE_W-1:0]  entry_cause_o,
  input logic [SR_W-1:0]     new_status_o,
  input logic                saved_we_o,
  input logic [XLEN-1:0]     new_pc_o,
  input logic [XLEN-1:0]     next_pc_o,
  input logic                vec_err_o,
  input logic                mode_err_o
);
  AST_ENTRY_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
    (|req_i) |=> entry_valid_o); // R1
  AST_IDLE_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
    !(|req_i) |=> !entry_valid_o); // R1
  AST_RESET_WINS: assert property (@(posedge clk) disable iff (rst)
    req_i[0] |=> (entry_cause_o == 3'd0)); // R1
  AST_VEC_SLOT: assert property (@(posedge clk) disable iff (rst)
    entry_valid_o |-> (new_pc_o[1:0] == 2'b00 && new_pc_o[4:0] != 5'h14)); // R2
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    entry_valid_o |-> new_status_o[SB_I]); // R6
  AST_ITJ_CLEAR: assert property (@(posedge clk) disable iff (rst)
    entry_valid_o |-> ((new_status_o & SR_ITJ_MASK) == '0)); // R7
  AST_BANK_WRITE: assert property (@(posedge clk) disable iff (rst)
    entry_valid_o |-> (saved_we_o && !mode_err_o)); // R8
  AST_NEXT_PC: assert property (@(posedge clk) disable iff (rst)
    entry_valid_o |-> (next_pc_o == new_pc_o + (new_status_o[SB_T] ? XLEN'(2) : XLEN'(4)))); // R9
  AST_VEC_ERR_WITH_ENTRY: assert property (@(posedge clk) disable iff (rst)
    vec_err_o |-> entry_valid_o); // R10
endmodule

bind exc_entry_ctrl exc_entry_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [6:0]  req = '0;
  logic [31:0] pc = '0, status = '0;
  logic [3:0]  flags = '0;
  logic        te = 1'b0, hivec = 1'b0, vecirq = 1'b0;

  logic        ev, swe, verr, merr;
  logic [2:0]  cause, bank;
  logic [31:0] nst, lnk, sav, npc, nxt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  exc_entry_ctrl i_exc_entry_ctrl (
    .clk(clk), .rst(rst), .req_i(req), .pc_i(pc), .status_i(status),
    .flags_i(flags), .ctl_te_i(te), .ctl_hivec_i(hivec), .ctl_vecirq_i(vecirq),
    .entry_valid_o(ev), .entry_cause_o(cause), .new_status_o(nst), .link_o(lnk),
    .saved_we_o(swe), .saved_bank_o(bank), .saved_o(sav), .new_pc_o(npc),
    .next_pc_o(nxt), .vec_err_o(verr), .mode_err_o(merr)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  function automatic int winner(input logic [6:0] r);
    int ord [7] = '{0, 4, 6, 5, 3, 1, 2};
    for (int i = 0; i < 7; i++) if (r[ord[i]]) return ord[i];
    return -1;
  endfunction

  function automatic logic [31:0] vec_of(input int c);
    return (c == 5 || c == 6) ? 32'(c * 4 + 4) : 32'(c * 4);
  endfunction

  function automatic logic [4:0] mode_of(input int c);
    case (c)
      0, 2: return 5'h13;
      1: return 5'h1B;
      3, 4: return 5'h17;
      5: return 5'h12;
      default: return 5'h11;
    endcase
  endfunction

  function automatic logic [2:0] bank_of(input int c);
    case (c)
      6: return 3'd0;
      5: return 3'd1;
      0, 2: return 3'd2;
      1: return 3'd3;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [31:0] lr_of(input int c, input bit narrow);
    if (c == 0) return 0;
    if (c == 4) return 8;
    if (narrow && (c == 1 || c == 2)) return 2;
    return 4;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] pats [3] = '{32'h0000_0000, 32'hFFFF_FFFF, 32'h5A00_7E60};
    logic [31:0] keep_pc, keep_st;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 valid", {31'b0, ev}, 0);
    check("R11 status", nst, 0);
    check("R11 pc", npc | nxt | lnk | sav, 0);
    check("R11 strobes", {27'b0, swe, verr, merr, cause[0], bank[0]}, 0);
    rst = 1'b0;

    for (int m = 1; m < 128; m++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        int c;
        logic [31:0] exp_st, exp_sav, exp_pc;
        req    = 7'(m);
        status = pats[(m + cfg) % 3];
        status[5] = cfg[0];
        te     = cfg[1];
        hivec  = cfg[2];
        vecirq = cfg[3];
        flags  = 4'(m ^ cfg);
        pc     = (m == 127) ? 32'hFFFF_FFFC : (32'h8000_0000 ^ (32'(m) << 8) ^ (32'(cfg) << 2));
        c = winner(req);
        @(negedge clk);
        exp_st = status & ~32'h0700_FC00;
        exp_st[4:0] = mode_of(c);
        exp_st[5] = te;
        exp_st[7] = 1'b1;
        exp_st[8] = status[8] | (c != 1 && c != 2);
        exp_st[6] = status[6] | (c == 0 || c == 6);
        exp_sav = status | {flags, 28'b0};
        exp_pc  = vec_of(c) + (hivec ? 32'hFFFF_0000 : 0);
        check("R1 valid", {31'b0, ev}, 1);
        check("R1 cause", {29'b0, cause}, 32'(c));
        check("R2 vector", npc, exp_pc);
        check("R3 mode", {27'b0, nst[4:0]}, {27'b0, mode_of(c)});
        if (!status[5]) check("R4 link wide", lnk, pc + lr_of(c, 1'b0));
        else            check("R5 link narrow", lnk, pc + lr_of(c, 1'b1));
        check("R6 masks", {29'b0, nst[8:6]}, {29'b0, exp_st[8:6]});
        check("R7 status", nst, exp_st);
        check("R8 saved", sav, exp_sav);
        check("R8 bank", {28'b0, swe, bank}, {28'b0, 1'b1, bank_of(c)});
        check("R8 mode_err", {31'b0, merr}, 0);
        check("R9 next pc", nxt, exp_pc + (te ? 2 : 4));
        check("R10 vec err", {31'b0, verr}, {31'b0, vecirq});
      end
    end

    // R1/R11: idle cycle, no strobe, held outputs
    keep_pc = npc; keep_st = nst;
    req = '0; status = 32'h1234_5678; pc = 32'h40;
    @(negedge clk);
    check("R1 idle valid", {29'b0, ev, swe, verr}, 0);
    check("R11 hold pc", npc, keep_pc);
    check("R11 hold status", nst, keep_st);

    // R11: reset clears after activity
    req = 7'h7F; rst = 1'b1;
    @(negedge clk);
    check("R11 reset clears", {31'b0, ev} | nst | npc, 0);
    rst = 1'b0; req = '0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule